// File: doc/BRIEF.md
# Device Configuration Sequencing Controller

This block steps a programmable logic device from power-on to normal operation. The phases always run in this order: power-up, initialization, configuration, start-up and operation. While power is settling, a power-on delay counter runs. During initialization the block requests a clear of configuration memory and holds the shared active-low init line low. In configuration it releases that line, drives the status pins and enables the serial data output. Start-up then turns on the user I/O, releases the internal reset and raises DONE.

The init line is open-drain and wire-ANDed between several devices. Any device, or an external agent, can keep the whole group in initialization by holding the line low. A device enters configuration only after it has seen the line high for two synchronized clock cycles in a row, and it captures the mode pins at that moment. Certain conditions send the controller back to initialization: a bit error, a low on the reset, program or init lines during configuration, or a program request during operation. After one configuration has fully completed, an option input allows reconfiguration without clearing memory first.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After rst_ni, and during power-up: init_pd_o=1, hdc_o=1, ldc_o=0, int_rst_o=1, io_act_o=0, done_o=0, dout_en_o=0, mem_clr_req_o=0.
- R2: A counter starts when pwr_good_i goes high and restarts whenever pwr_good_i drops. Initialization (mem_clr_req_o=1) starts exactly POR_CYC+1 clock edges after pwr_good_i was last seen high continuously.
- R3: In initialization with a clear required, mem_clr_req_o=1 and init_pd_o=1 until a mem_clr_done_i pulse. Both are 0 from the next edge on.
- R4: While the observed init line is held low externally, the controller stays in initialization (dout_en_o=0).
- R5: After init_pd_o is released, the init line must be high for two consecutive synchronized cycles. A single-cycle high is ignored. From a rising line, configuration starts on the 5th clock edge (2 synchronizer + 2 qualification + 1 transition).
- R6: cfg_mode_o takes mode_i on the edge that enters configuration and holds it until the next entry.
- R7: In configuration: init_pd_o=0, hdc_o=1, ldc_o=0, dout_en_o=1, done_o=0.
- R8: load_done_i moves configuration to start-up only if frame_wr_i has pulsed at least once in the current configuration pass. Otherwise it is ignored.
- R9: In configuration, bit_err_i=1 returns to initialization on the next edge. A synchronized low on ext_rst_ni, prog_ni or the init line also returns to initialization.
- R10: Start-up drives io_act_o=1, int_rst_o=0, done_o=1, hdc_o=0, ldc_o=1 for SU_CYC cycles, then enters operation. A synchronized low on ext_rst_ni or prog_ni during start-up returns to initialization.
- R11: In operation, ext_rst_ni is ignored. A synchronized low on prog_ni returns to initialization.
- R12: With keep_mem_i=1, the memory clear is skipped (mem_clr_req_o stays 0) only once a configuration has reached operation. Before that, or with keep_mem_i=0, the clear is always requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller |
| pwr_good_i | input | 1 | Supply is in range |
| ext_rst_ni | input | 1 | Active-low reset pin (asynchronous, synchronized inside) |
| prog_ni | input | 1 | Active-low program request (synchronized inside) |
| init_line_i | input | 1 | Observed level of the shared wire-ANDed init line |
| mode_i | input | MODE_W | Mode select pins |
| frame_wr_i | input | 1 | A configuration frame was written |
| bit_err_i | input | 1 | Bitstream error detected |
| load_done_i | input | 1 | Bitstream loading finished |
| mem_clr_done_i | input | 1 | Configuration memory clear finished |
| keep_mem_i | input | 1 | Option: skip clear on reconfiguration |
| init_pd_o | output | 1 | Enable of the init line pull-down |
| hdc_o | output | 1 | High-during-configuration status |
| ldc_o | output | 1 | Low-during-configuration status |
| dout_en_o | output | 1 | Serial data output enable |
| mem_clr_req_o | output | 1 | Request to clear configuration memory |
| io_act_o | output | 1 | User I/O active |
| int_rst_o | output | 1 | Internal reset to user logic |
| done_o | output | 1 | Configuration complete |
| cfg_mode_o | output | MODE_W | Mode captured at configuration entry |

## Verification
The hardest cases to reach from the ports are the ones where the controller must stay put on the init line: a release of exactly one cycle, and the exact edge of configuration entry after a clean release. The bench models the wire-AND itself, combining the block's own pull-down with an external holder. It opens that holder for a single cycle, then for good, and counts edges to the transition. A reset that arrives during the short start-up window is timed from the load-done edge so that the synchronized low lands inside start-up. The run also checks that the aborted pass does not count as a first configuration, which the keep-memory option depends on.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP   = 3'd0,
    ST_INIT    = 3'd1,
    ST_CFG     = 3'd2,
    ST_STARTUP = 3'd3,
    ST_OPER    = 3'd4
  } phase_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
  parameter int unsigned POR_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic por_done_o
);
  localparam int unsigned CNT_W = $clog2(POR_CYC + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(POR_CYC);

  logic [CNT_W-1:0] cnt_q;

  // restart whenever supply indication drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!pwr_good_i) cnt_q <= '0;
    else if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
  end

  assign por_done_o = (cnt_q == TERM);
endmodule

// File: rtl/cfg_init_qual.sv
module cfg_init_qual #(
  parameter int unsigned HI_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_i,
  output logic ok_o
);
  localparam int unsigned CNT_W = $clog2(HI_CYC + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(HI_CYC);

  logic [CNT_W-1:0] cnt_q;

  // consecutive-high counter, cleared by any low sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!(en_i && line_i)) cnt_q <= '0;
    else if (cnt_q != TERM)     cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == TERM);
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int unsigned MODE_W      = 3,
  parameter int unsigned POR_CYC     = 1024,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned INIT_HI_CYC = 2,
  parameter int unsigned SU_CYC      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              ext_rst_ni,
  input  logic              prog_ni,
  input  logic              init_line_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              frame_wr_i,
  input  logic              bit_err_i,
  input  logic              load_done_i,
  input  logic              mem_clr_done_i,
  input  logic              keep_mem_i,
  output logic              init_pd_o,
  output logic              hdc_o,
  output logic              ldc_o,
  output logic              dout_en_o,
  output logic              mem_clr_req_o,
  output logic              io_act_o,
  output logic              int_rst_o,
  output logic              done_o,
  output logic [MODE_W-1:0] cfg_mode_o
);
  localparam int unsigned SU_W = $clog2(SU_CYC + 1);
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(SU_CYC - 1);

  phase_e            st_q, st_d;
  logic [2:0]        pins_s;
  logic              rst_s, prog_s, init_s;
  logic              por_done, init_ok;
  logic              clr_ok_q, clr_ok_d;
  logic              cfg_once_q, frame_seen_q;
  logic [SU_W-1:0]   su_cnt_q;
  logic [MODE_W-1:0] mode_q;
  logic              clr_need, lines_hi;

  // {reset, program, init}; active-low pins reset to inactive, init to low
  cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_rst_ni, prog_ni, init_line_i}),
    .q_o   (pins_s)
  );
  assign {rst_s, prog_s, init_s} = pins_s;

  cfg_por_timer #(.POR_CYC(POR_CYC)) u_por (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .por_done_o(por_done)
  );

  cfg_init_qual #(.HI_CYC(INIT_HI_CYC)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (st_q == ST_INIT && clr_ok_q),
    .line_i(init_s),
    .ok_o  (init_ok)
  );

  assign clr_need = !(keep_mem_i && cfg_once_q);
  assign lines_hi = rst_s && prog_s;

  always_comb begin
    st_d     = st_q;
    clr_ok_d = clr_ok_q;
    unique case (st_q)
      ST_PWRUP: if (por_done) begin
        st_d = ST_INIT; clr_ok_d = 1'b0;
      end
      ST_INIT: begin
        if (!lines_hi)                                 clr_ok_d = 1'b0;
        else if (!clr_ok_q && (!clr_need || mem_clr_done_i)) clr_ok_d = 1'b1;
        if (lines_hi && clr_ok_q && init_ok)           st_d = ST_CFG;
      end
      ST_CFG: begin
        if (!lines_hi || !init_s || bit_err_i) begin
          st_d = ST_INIT; clr_ok_d = 1'b0;
        end else if (load_done_i && (frame_seen_q || frame_wr_i)) begin
          st_d = ST_STARTUP;
        end
      end
      ST_STARTUP: begin
        if (!lines_hi) begin
          st_d = ST_INIT; clr_ok_d = 1'b0;
        end else if (su_cnt_q == SU_LAST) begin
          st_d = ST_OPER;
        end
      end
      ST_OPER: if (!prog_s) begin
        st_d = ST_INIT; clr_ok_d = 1'b0;
      end
      default: st_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_PWRUP;
      clr_ok_q     <= 1'b0;
      cfg_once_q   <= 1'b0;
      frame_seen_q <= 1'b0;
      su_cnt_q     <= '0;
      mode_q       <= '0;
    end else begin
      st_q     <= st_d;
      clr_ok_q <= clr_ok_d;
      if (st_q == ST_INIT && st_d == ST_CFG) begin
        mode_q       <= mode_i;
        frame_seen_q <= 1'b0;
      end else if (st_q == ST_CFG && frame_wr_i) begin
        frame_seen_q <= 1'b1;
      end
      if (st_q == ST_STARTUP) su_cnt_q <= su_cnt_q + 1'b1;
      else                    su_cnt_q <= '0;
      // only a pass that reaches operation counts as first configuration
      if (st_d == ST_OPER) cfg_once_q <= 1'b1;
    end
  end

  always_comb begin
    init_pd_o     = (st_q == ST_PWRUP) || (st_q == ST_INIT && !clr_ok_q);
    mem_clr_req_o = (st_q == ST_INIT) && !clr_ok_q && clr_need;
    dout_en_o     = (st_q == ST_CFG);
    io_act_o      = (st_q == ST_STARTUP) || (st_q == ST_OPER);
    done_o        = io_act_o;
    int_rst_o     = !io_act_o;
    hdc_o         = !io_act_o;
    ldc_o         = io_act_o;
  end

  assign cfg_mode_o = mode_q;
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk
  import cfg_seq_pkg::*;
#(
  parameter int unsigned MODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input phase_e            st_i,
  input logic              prog_s_i,
  input logic              init_pd_o,
  input logic              mem_clr_req_o,
  input logic              mem_clr_done_i,
  input logic              dout_en_o,
  input logic              bit_err_i,
  input logic              done_o,
  input logic [MODE_W-1:0] cfg_mode_o
);
  p_pd_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_pd_o) |-> ($past(mem_clr_done_i) || !$past(mem_clr_req_o)));

  p_cfg_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_en_o) |-> $past(!init_pd_o));

  p_mode_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(dout_en_o) |-> $stable(cfg_mode_o));

  p_biterr_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_en_o && bit_err_i) |=> (!dout_en_o && !done_o && init_pd_o));

  p_oper_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_OPER && prog_s_i) |=> (st_i == ST_OPER && done_o));
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .st_i          (st_q),
  .prog_s_i      (prog_s),
  .init_pd_o     (init_pd_o),
  .mem_clr_req_o (mem_clr_req_o),
  .mem_clr_done_i(mem_clr_done_i),
  .dout_en_o     (dout_en_o),
  .bit_err_i     (bit_err_i),
  .done_o        (done_o),
  .cfg_mode_o    (cfg_mode_o)
);

// File: tb/sim_cfg_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_seq_ctrl;
  localparam int MODE_W = 3;
  localparam int POR    = 8;
  localparam int SU     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, ext_rst_n = 1'b1, prog_n = 1'b1, ext_hold = 1'b0;
  logic [MODE_W-1:0] mode = '0;
  logic frame_wr = 1'b0, bit_err = 1'b0, load_done = 1'b0, clr_done = 1'b0, keep_mem = 1'b0;
  logic init_pd, hdc, ldc, dout_en, clr_req, io_act, int_rst, done;
  logic [MODE_W-1:0] cfg_mode;
  logic init_line;

  int total = 0, bad = 0;
  bit saw_req;

  always #4 clk = ~clk;

  // wire-AND: own pull-down or external holder pulls the line low
  assign init_line = !init_pd && !ext_hold;

  cfg_seq_ctrl #(.MODE_W(MODE_W), .POR_CYC(POR), .SU_CYC(SU)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .ext_rst_ni(ext_rst_n),
    .prog_ni(prog_n), .init_line_i(init_line), .mode_i(mode), .frame_wr_i(frame_wr),
    .bit_err_i(bit_err), .load_done_i(load_done), .mem_clr_done_i(clr_done),
    .keep_mem_i(keep_mem), .init_pd_o(init_pd), .hdc_o(hdc), .ldc_o(ldc),
    .dout_en_o(dout_en), .mem_clr_req_o(clr_req), .io_act_o(io_act),
    .int_rst_o(int_rst), .done_o(done), .cfg_mode_o(cfg_mode)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_config();
    for (int i = 0; i < 40; i++) begin
      if (dout_en) break;
      if (clr_req) begin clr_done = 1'b1; tick(1); clr_done = 1'b0; end
      else tick(1);
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 init_pd", init_pd, 1); chk("R1 hdc", hdc, 1); chk("R1 ldc", ldc, 0);
    chk("R1 int_rst", int_rst, 1); chk("R1 io_act", io_act, 0); chk("R1 done", done, 0);
    chk("R1 dout_en", dout_en, 0); chk("R1 clr_req", clr_req, 0);

    // R2 power-on delay, with a restart
    tick(20);
    chk("R2 no init without power", clr_req, 0);
    pwr_good = 1'b1; tick(5); pwr_good = 1'b0; tick(1); pwr_good = 1'b1;
    tick(POR);
    chk("R2 still powering up", clr_req, 0);
    tick(1);
    chk("R2 init entered", clr_req, 1);

    // R3 pull-down held until clear done
    tick(10);
    chk("R3 pd held", init_pd, 1); chk("R3 req held", clr_req, 1);
    ext_hold = 1'b1;
    clr_done = 1'b1; tick(1); clr_done = 1'b0;
    chk("R3 pd released", init_pd, 0); chk("R3 req dropped", clr_req, 0);

    // R4 external hold keeps init
    tick(12);
    chk("R4 held in init", dout_en, 0);

    // R5 single-cycle release ignored
    ext_hold = 1'b0; tick(1); ext_hold = 1'b1;
    tick(10);
    chk("R5 glitch ignored", dout_en, 0);

    // R5 exact entry edge, R6 mode capture
    mode = 3'd5; ext_hold = 1'b0;
    tick(4);
    chk("R5 not yet in config", dout_en, 0);
    tick(1);
    chk("R5 config entered", dout_en, 1);
    mode = 3'd3; tick(3);
    chk("R6 mode captured", cfg_mode, 5);

    // R7 configuration outputs
    chk("R7 init_pd", init_pd, 0); chk("R7 hdc", hdc, 1); chk("R7 ldc", ldc, 0);
    chk("R7 done", done, 0);

    // R8 load done without a frame is ignored
    load_done = 1'b1; tick(1); load_done = 1'b0; tick(2);
    chk("R8 no startup without frame", done, 0);
    chk("R8 still configuring", dout_en, 1);

    // R9 bit error aborts
    bit_err = 1'b1; tick(1); bit_err = 1'b0;
    chk("R9 biterr dout", dout_en, 0); chk("R9 biterr pd", init_pd, 1);
    chk("R9 biterr clear", clr_req, 1);
    go_config();
    chk("R9 back in config", dout_en, 1);
    // R9 init line pulled low externally
    ext_hold = 1'b1; tick(1); ext_hold = 1'b0; tick(4);
    chk("R9 init low aborts", dout_en, 0);
    go_config();
    // R9 program low
    prog_n = 1'b0; tick(4);
    chk("R9 prog low aborts", dout_en, 0);
    prog_n = 1'b1;
    go_config();
    chk("R9 config again", dout_en, 1);

    // R10 reset during startup aborts; R12 aborted pass is not a first config
    frame_wr = 1'b1; tick(1); frame_wr = 1'b0;
    load_done = 1'b1; tick(1); load_done = 1'b0;
    chk("R10 done", done, 1); chk("R10 io_act", io_act, 1); chk("R10 int_rst", int_rst, 0);
    chk("R10 hdc", hdc, 0); chk("R10 ldc", ldc, 1);
    ext_rst_n = 1'b0; tick(1);
    chk("R10 still startup", done, 1);
    tick(3);
    chk("R10 reset aborts startup", done, 0);
    ext_rst_n = 1'b1; keep_mem = 1'b1; tick(3);
    chk("R12 clear before first config", clr_req, 1);

    // R10 full startup to operation
    go_config();
    frame_wr = 1'b1; tick(1); frame_wr = 1'b0;
    load_done = 1'b1; tick(1); load_done = 1'b0;
    tick(SU + 2);
    chk("R10 in operation", done, 1);

    // R11 reset ignored in operation
    ext_rst_n = 1'b0; tick(8);
    chk("R11 reset ignored", done, 1);
    ext_rst_n = 1'b1; tick(3);

    // R11 program returns to init; R12 clear skipped
    saw_req = 1'b0;
    prog_n = 1'b0; tick(4);
    chk("R11 prog leaves operation", done, 0);
    chk("R12 pd while prog low", init_pd, 1);
    if (clr_req) saw_req = 1'b1;
    prog_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      if (dout_en) break;
      if (clr_req) saw_req = 1'b1;
      tick(1);
    end
    chk("R12 no clear requested", saw_req, 0);
    chk("R12 config without clear", dout_en, 1);

    // R12 option off: clear requested again
    keep_mem = 1'b0;
    bit_err = 1'b1; tick(1); bit_err = 1'b0;
    chk("R12 clear with option off", clr_req, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule